// File: doc/BRIEF.md
# Peripheral Controller Busy/Done Register Front End

This block is the processor-facing register front end of a peripheral controller. Software reaches it through a small read/write register bus. Through that bus it finds a command register, a status register and a bank of data registers. The status register reports the busy and done flags and an error code. A two-bit busy/done state code runs the handshake between software and the controller. Software first loads the data registers. It then writes a command while the controller is idle. The controller reports busy until its modelled device finishes after a fixed number of cycles. It then reports done and raises an interrupt-pending flag.

Software consumes the result and clears done to return the controller to idle. The interrupt flag can also be dropped early through a dedicated acknowledge input. The modelled device behaves as follows. A read operation fills the data registers from a generated pattern. A write operation copies the data registers into a capture register that is visible on an output port. Any other command code completes with a nonzero error code.

The state machine has three named states: IDLE (code 00), WORK (code 01) and DONE (code 10). It has three named transitions. START goes from IDLE to WORK on a command write. FINISH goes from WORK to DONE when the delay counter expires. RELEASE goes from DONE to IDLE on a status write that clears done.

Top module: `devctl_regif`

## Requirements
- R1: Status (offset 1) reads busy in bit 0, done in bit 1, the error code in bits 7:4 and zero in bits 3:2. Busy and done are never both 1.
- R2: A command write (offset 0) while busy or done is set is ignored. The state, the error code and the command read back from offset 0 are all unchanged.
- R3: A command write in IDLE stores the value, which reads back at offset 0, and sets busy from the next clock edge.
- R4: Busy stays set for exactly DELAY clock cycles (default 8). It then clears on the same edge that sets done.
- R5: irq_pend rises on the edge where busy falls.
- R6: A one-cycle pulse on irq_ack clears irq_pend and leaves done set.
- R7: In DONE, a status write with bit 1 = 0 returns the controller to IDLE and clears irq_pend. A status write with bit 1 = 1 has no effect.
- R8: Data registers at offsets 2 to 5 (data 0 to data 3) are writable and readable when not busy. Writes to them while busy are ignored.
- R9: Completion of a READ command (code 1) loads data register i with 0xA5 ^ (i*0x11) ^ n. Here n is the number of earlier READ completions since reset, modulo 256.
- R10: Completion of a WRITE command (code 2) copies data register i into cap_data bits [8i+7:8i].
- R11: Any other command code completes with error code 1 in status bits 7:4 and leaves the data registers and cap_data unchanged. READ and WRITE complete with error code 0. The error code is held until the next accepted command.
- R12: After reset the status, command, data registers, cap_data and irq_pend are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_pend | output | 1 | Interrupt pending toward the processor |
| cap_data | output | 32 | Capture register filled by WRITE commands |

## Verification
A command write takes effect on its own clock edge, so busy is visible at the falling edge that follows. Done and irq_pend appear together exactly DELAY edges later. The bench drives every access at a falling edge and samples the combinational read data half a nanosecond later. It counts the falling edges on which busy reads 1 and compares that count with DELAY. It reads status, data and cap_data one falling edge after the completion edge, and it checks that ignored writes and ignored commands leave the read-back values unchanged.

// File: rtl/devctl_pkg.sv
package devctl_pkg;

    // Handshake state; the code is the {done, busy} pair shown in status
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WORK = 2'b01,
        ST_DONE = 2'b10
    } hs_state_t;

    localparam int ADDR_CMD   = 0;
    localparam int ADDR_STAT  = 1;
    localparam int ADDR_DATA0 = 2;

    localparam int CMD_READ   = 1;
    localparam int CMD_WRITE  = 2;

    localparam int ERRW       = 4;
    localparam int ERR_LSB    = 4;
    localparam logic [ERRW-1:0] ERR_BADCMD = 4'h1;

endpackage

// File: rtl/devctl_fsm.sv
module devctl_fsm
    import devctl_pkg::*;
#(
    parameter int DELAY = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_req,
    input  logic      clr_done_req,
    input  logic      irq_ack,
    output hs_state_t state_q,
    output logic      finish,
    output logic      irq_pend
);
    localparam int CW = $clog2(DELAY + 1);

    hs_state_t     state_d;
    logic [CW-1:0] cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: START, FINISH, RELEASE
    always_comb begin
        state_d = state_q;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_req) state_d = ST_WORK;
            ST_WORK: if (cnt_q == '0) begin
                state_d = ST_DONE;
                finish  = 1'b1;
            end
            ST_DONE: if (clr_done_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Modelled device delay
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (state_q == ST_IDLE && start_req) cnt_q <= CW'(DELAY - 1);
        else if (state_q == ST_WORK && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // Interrupt-pending output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        irq_pend <= 1'b0;
        else if (finish)   irq_pend <= 1'b1;
        else if (irq_ack || (state_q == ST_DONE && clr_done_req))
                           irq_pend <= 1'b0;
    end

    // Checker-only length of the current busy run
    logic [CW:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  run_q <= '0;
        else if (state_q == ST_WORK) run_q <= run_q + 1'b1;
        else                         run_q <= '0;
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_req) |=> state_q == ST_WORK); // R3
    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= (CW+1)'(DELAY)); // R4
    AST_IRQ_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WORK && state_d != ST_WORK) |=> (irq_pend && state_q == ST_DONE)); // R5
    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && clr_done_req) |=> (state_q == ST_IDLE && !irq_pend)); // R7

endmodule

// File: rtl/devctl_databank.sv
module devctl_databank #(
    parameter int          DW       = 8,
    parameter int          NDATA    = 4,
    parameter logic [7:0]  PAT_BASE = 8'hA5,
    localparam int         IW       = (NDATA > 1) ? $clog2(NDATA) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [IW-1:0]       idx_i,
    input  logic [DW-1:0]       wdata_i,
    input  logic                busy_i,
    input  logic                fill_i,
    input  logic                cap_i,
    output logic [NDATA*DW-1:0] data_flat,
    output logic [NDATA*DW-1:0] cap_flat
);
    logic [DW-1:0] seq_q;

    // Count of READ completions, mixed into the pattern
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      seq_q <= '0;
        else if (fill_i) seq_q <= seq_q + 1'b1;
    end

    for (genvar g = 0; g < NDATA; g++) begin : g_slot
        logic [DW-1:0] reg_q;
        logic [DW-1:0] cap_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                reg_q <= '0;
            else if (fill_i)
                reg_q <= DW'(PAT_BASE) ^ DW'(g * 17) ^ seq_q;
            else if (we_i && !busy_i && idx_i == IW'(g))
                reg_q <= wdata_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cap_q <= '0;
            else if (cap_i) cap_q <= reg_q;
        end

        assign data_flat[g*DW +: DW] = reg_q;
        assign cap_flat[g*DW +: DW]  = cap_q;
    end

    AST_DATA_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !fill_i) |=> $stable(data_flat)); // R8
    AST_CAP_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(cap_flat)); // R10

endmodule

// File: rtl/devctl_regif.sv
module devctl_regif
    import devctl_pkg::*;
#(
    parameter int         DW       = 8,
    parameter int         NDATA    = 4,
    parameter int         DELAY    = 8,
    parameter logic [7:0] PAT_BASE = 8'hA5,
    localparam int        AW       = $clog2(NDATA + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic                irq_ack,
    output logic                irq_pend,
    output logic [NDATA*DW-1:0] cap_data
);
    localparam int IW = (NDATA > 1) ? $clog2(NDATA) : 1;

    hs_state_t         state;
    logic              finish;
    logic              wr, cmd_wr, stat_wr, data_hit, start_req, clr_done_req, busy;
    logic [IW-1:0]     data_idx;
    logic [DW-1:0]     cmd_q;
    logic [ERRW-1:0]   err_q;
    logic [DW-1:0]     status;
    logic [NDATA*DW-1:0] data_flat;
    logic              cmd_known;

    // Register decode
    always_comb begin
        wr           = bus_sel && bus_we;
        cmd_wr       = wr && bus_addr == AW'(ADDR_CMD);
        stat_wr      = wr && bus_addr == AW'(ADDR_STAT);
        data_hit     = bus_addr >= AW'(ADDR_DATA0) && bus_addr < AW'(ADDR_DATA0 + NDATA);
        data_idx     = IW'(bus_addr - AW'(ADDR_DATA0));
        start_req    = cmd_wr && state == ST_IDLE;
        clr_done_req = stat_wr && !bus_wdata[1];
        busy         = state == ST_WORK;
        cmd_known    = cmd_q == DW'(CMD_READ) || cmd_q == DW'(CMD_WRITE);
    end

    devctl_fsm #(.DELAY(DELAY)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req),
        .clr_done_req (clr_done_req),
        .irq_ack      (irq_ack),
        .state_q      (state),
        .finish       (finish),
        .irq_pend     (irq_pend)
    );

    devctl_databank #(.DW(DW), .NDATA(NDATA), .PAT_BASE(PAT_BASE)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (wr && data_hit),
        .idx_i     (data_idx),
        .wdata_i   (bus_wdata),
        .busy_i    (busy),
        .fill_i    (finish && cmd_q == DW'(CMD_READ)),
        .cap_i     (finish && cmd_q == DW'(CMD_WRITE)),
        .data_flat (data_flat),
        .cap_flat  (cap_data)
    );

    // Command and error registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cmd_q <= '0;
        else if (start_req) cmd_q <= bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         err_q <= '0;
        else if (start_req) err_q <= '0;
        else if (finish)    err_q <= cmd_known ? '0 : ERR_BADCMD;
    end

    // Status word and read mux
    always_comb begin
        status                     = '0;
        status[1:0]                = state;
        status[ERR_LSB +: ERRW]    = err_q;
        bus_rdata                  = '0;
        if (bus_sel && !bus_we) begin
            if (bus_addr == AW'(ADDR_CMD))       bus_rdata = cmd_q;
            else if (bus_addr == AW'(ADDR_STAT)) bus_rdata = status;
            else if (data_hit)                   bus_rdata = data_flat[data_idx*DW +: DW];
        end
    end

    AST_NO_BUSY_AND_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == AW'(ADDR_STAT)) |-> bus_rdata[1:0] != 2'b11); // R1
    AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && state != ST_IDLE) |=> $stable(cmd_q)); // R2
    AST_ERR_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !cmd_known) |=> err_q == ERR_BADCMD); // R11

endmodule

// File: tb/devctl_regif_tb.sv
`timescale 1ns/1ps
module devctl_regif_tb;
    localparam int DELAY = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0, irq_ack = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_pend;
    logic [31:0] cap_data;

    int chk_cnt = 0;
    int err_cnt = 0;
    int rd_seq  = 0;

    always #2.5 clk = ~clk;

    devctl_regif #(.DELAY(DELAY)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_ack(irq_ack), .irq_pend(irq_pend), .cap_data(cap_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk_cnt++;
        if (act !== exp) begin
            err_cnt++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_busy(output int n);
        logic [7:0] s;
        n = 0;
        rd(3'd1, s);
        while (s[0]) begin
            n++;
            @(negedge clk);
            rd(3'd1, s);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int seq);
        return 8'hA5 ^ 8'(i * 17) ^ 8'(seq);
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        rd(3'd1, d); chk("R12 status", d, 8'h00);
        rd(3'd0, d); chk("R12 command", d, 8'h00);
        for (int i = 0; i < 4; i++) begin
            rd(3'(2 + i), d); chk("R12 data", d, 8'h00);
        end
        chk("R12 irq", irq_pend, 1'b0);
        chk("R12 capture", cap_data, 32'h0);
    endtask

    task automatic t_write_op();
        logic [7:0] d; int n;
        wr(3'd2, 8'h11); wr(3'd3, 8'h22); wr(3'd4, 8'h33); wr(3'd5, 8'h44);
        rd(3'd2, d); chk("R8 idle write data0", d, 8'h11);
        wr(3'd0, 8'd2);
        rd(3'd1, d); chk("R3 busy after command", d, 8'h01);
        rd(3'd0, d); chk("R3 command readback", d, 8'h02);
        wait_busy(n);
        chk("R4 busy length", n, DELAY);
        rd(3'd1, d); chk("R1 status done", d, 8'h02);
        chk("R5 irq at completion", irq_pend, 1'b1);
        chk("R10 capture", cap_data, 32'h44332211);
    endtask

    task automatic t_cmd_while_done();
        logic [7:0] d;
        wr(3'd0, 8'd1);
        rd(3'd1, d); chk("R2 status kept done", d, 8'h02);
        rd(3'd0, d); chk("R2 command unchanged", d, 8'h02);
        repeat (3) @(negedge clk);
        rd(3'd1, d); chk("R2 no late start", d, 8'h02);
    endtask

    task automatic t_irq_ack();
        logic [7:0] d;
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk("R6 irq cleared by ack", irq_pend, 1'b0);
        rd(3'd1, d); chk("R6 done kept", d, 8'h02);
    endtask

    task automatic t_clear_done();
        logic [7:0] d;
        wr(3'd1, 8'h02);
        rd(3'd1, d); chk("R7 bit1 set no effect", d, 8'h02);
        wr(3'd1, 8'h00);
        rd(3'd1, d); chk("R7 back to idle", d, 8'h00);
    endtask

    task automatic t_read_op();
        logic [7:0] d; int n;
        wr(3'd0, 8'd1);
        wait_busy(n);
        chk("R4 read busy length", n, DELAY);
        rd(3'd1, d); chk("R11 read error zero", d, 8'h02);
        for (int i = 0; i < 4; i++) begin
            rd(3'(2 + i), d); chk("R9 read pattern", d, pat(i, rd_seq));
        end
        rd_seq++;
        chk("R5 irq after read", irq_pend, 1'b1);
        wr(3'd1, 8'h00);
        chk("R7 clear done drops irq", irq_pend, 1'b0);
        rd(3'd1, d); chk("R7 idle after read", d, 8'h00);
    endtask

    task automatic t_busy_writes();
        logic [7:0] d; int n;
        logic [7:0] exp [4];
        for (int i = 0; i < 4; i++) begin
            rd(3'(2 + i), exp[i]);
        end
        wr(3'd0, 8'd2);
        wr(3'd2, 8'hFF);
        wr(3'd0, 8'd7);
        rd(3'd0, d); chk("R2 command ignored while busy", d, 8'h02);
        wait_busy(n);
        rd(3'd2, d); chk("R8 busy write ignored", d, exp[0]);
        chk("R10 capture of pattern", cap_data, {exp[3], exp[2], exp[1], exp[0]});
        rd(3'd1, d); chk("R2 no error from ignored command", d, 8'h02);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_bad_cmd();
        logic [7:0] d; int n;
        logic [31:0] cap0;
        logic [7:0] exp0;
        cap0 = cap_data;
        rd(3'd2, exp0);
        wr(3'd0, 8'd7);
        wait_busy(n);
        chk("R4 bad busy length", n, DELAY);
        rd(3'd1, d); chk("R11 error code", d, 8'h12);
        rd(3'd2, d); chk("R11 data unchanged", d, exp0);
        chk("R11 capture unchanged", cap_data, cap0);
        wr(3'd1, 8'h00);
        rd(3'd1, d); chk("R11 error held in idle", d, 8'h10);
        wr(3'd0, 8'd1);
        rd(3'd1, d); chk("R11 error cleared on start", d, 8'h01);
        wait_busy(n);
        rd(3'd2, d); chk("R9 second read pattern", d, pat(0, rd_seq));
        rd(3'd5, d); chk("R9 second read data3", d, pat(3, rd_seq));
        rd_seq++;
        wr(3'd1, 8'h00);
    endtask

    initial begin
        #(200000 * 5);
        err_cnt++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", chk_cnt, err_cnt);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_op();
        t_cmd_while_done();
        t_irq_ack();
        t_clear_done();
        t_read_op();
        t_busy_writes();
        t_bad_cmd();
        $display("Simulation finished: %0d checks, %0d errors", chk_cnt, err_cnt);
        $finish;
    end

endmodule